// File: doc/BRIEF.md
# Lane Execution Mask Branch Unit

This block holds the per-lane execution mask of one wavefront while it runs structured if/else code on a SIMD datapath. Each cycle it takes one control opcode and, where the opcode needs it, a per-lane compare vector. It computes the next mask from the current mask, the compare vector and a small LIFO of saved masks. The mask gates lane writeback. Lanes whose mask bit is clear still take their issue slot, but they write nothing.

An if-body is entered by ANDing the compare vector into the mask. The else-body takes the saved mask with the if-lanes removed. A restore pops the saved mask back into place. After an if, an else or an explicit test, a one-cycle skip pulse tells the sequencer that no lane is active, so the body can be jumped over. Pushing onto a full save stack, or reading or popping an empty one, sets a sticky error flag. The offending operation then has no other effect. A launch pulse starts a new wavefront: it loads the mask from the valid-thread vector and empties the stack.

Opcodes on `op`: 0 = no operation, 1 = save, 2 = if, 3 = else, 4 = restore, 5 = test-for-empty. Codes 6 and 7 act as no operation. Every registered output changes at the clock edge that samples the opcode.

Top module: `lane_mask_unit`

## Requirements
- R1: During reset the mask is all ones, and skip and error are 0. When `launch` is sampled high, the mask becomes `valid_lanes`, the save stack is emptied, skip is 0 and the opcode is ignored.
- R2: Opcode 2 (if) sets the mask to `cmp & mask`.
- R3: Opcode 1 (save) pushes the current mask onto the stack and leaves the mask unchanged.
- R4: After opcode 2, skip is 1 exactly when the new mask is all zero.
- R5: Opcode 3 (else) sets the mask to `top & ~mask`, where top is the most recent saved mask. It leaves the stack unchanged.
- R6: After opcode 3, skip is 1 exactly when the new mask is all zero.
- R7: Opcode 4 (restore) sets the mask to the top saved mask and removes that entry.
- R8: Opcode 5 (test) leaves the mask unchanged and sets skip to 1 exactly when the mask is all zero.
- R9: Each of these sets the error flag: a save with DEPTH entries already held, or an else or restore with an empty stack. The offending operation does not change the mask or the stack, and its skip is 0. Only reset clears the error flag; launch does not.
- R10: `wb_en` equals `wb_req & exec_mask` in the same cycle.
- R11: Saves and restores nest in LIFO order up to DEPTH levels.
- R12: Skip is a single-cycle pulse. It is 0 after any opcode other than 2, 3 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start of a new wavefront |
| valid_lanes | input | LANES | Lanes holding live threads at launch |
| op | input | 3 | Control opcode |
| cmp | input | LANES | Per-lane compare result |
| wb_req | input | LANES | Per-lane writeback request |
| exec_mask | output | LANES | Current execution mask |
| skip | output | 1 | No lane active after if/else/test |
| stk_err | output | 1 | Sticky save-stack misuse flag |
| wb_en | output | LANES | Gated writeback enables |

## Verification
The bench drives each of the following cases and predicts the result:
- **All-false compare.** The mask becomes empty and skip must fire. A design that tests the raw compare instead of the masked one would miss the skip whenever inactive lanes compare true.
- **Else with the full saved set.** A design that forgot the NOT would re-run the if-lanes.
- **Nine saves in a row.** The ninth hits a full stack. A design that still wrote that entry, or wrapped its pointer, would hand back a wrong mask on the following restores.
- **Else on an empty stack.** This must flag the error and change no state.
- **Launch while the error flag is set.** The flag must survive the launch.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_SAVE    = 3'd1,
      OP_IF      = 3'd2,
      OP_ELSE    = 3'd3,
      OP_RESTORE = 3'd4,
      OP_TEST    = 3'd5
   } mask_op_e;
endpackage

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
   parameter int LANES = 64,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push,
   input  logic             pop,
   input  logic [LANES-1:0] push_data,
   output logic [LANES-1:0] top,
   output logic             empty,
   output logic             full
);
   localparam int PW = $clog2(DEPTH + 1);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [LANES-1:0] mem [DEPTH];
   logic [PW-1:0]    cnt;
   logic [PW-1:0]    top_idx;

   initial begin : p_param_chk
      assert (DEPTH >= 2) else $error("lane_mask_stack: DEPTH must be at least 2");
      assert (LANES >= 1) else $error("lane_mask_stack: LANES must be at least 1");
   end

   assign empty   = (cnt == '0);
   assign full    = (cnt == PW'(DEPTH));
   assign top_idx = cnt - PW'(1);
   assign top     = mem[top_idx[AW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         cnt <= '0;
      else if (push && !full)
         cnt <= cnt + PW'(1);
      else if (pop && !empty)
         cnt <= cnt - PW'(1);
   end

   always_ff @(posedge clk) begin
      if (push && !full && !clear)
         mem[cnt[AW-1:0]] <= push_data;
   end
endmodule

// File: rtl/lane_mask_next.sv
module lane_mask_next
   import lane_mask_pkg::*;
#(
   parameter int LANES = 64
) (
   input  mask_op_e         op,
   input  logic [LANES-1:0] cmp,
   input  logic [LANES-1:0] mask,
   input  logic [LANES-1:0] top,
   input  logic             empty,
   input  logic             full,
   output logic [LANES-1:0] nxt_mask,
   output logic             nxt_skip,
   output logic             push,
   output logic             pop,
   output logic             err_set
);
   logic [LANES-1:0] if_mask;
   logic [LANES-1:0] else_mask;

   assign if_mask   = cmp & mask;
   assign else_mask = top & ~mask;

   always_comb begin
      nxt_mask = mask;
      nxt_skip = 1'b0;
      push     = 1'b0;
      pop      = 1'b0;
      err_set  = 1'b0;
      unique case (op)
         OP_SAVE: begin
            push    = !full;
            err_set = full;
         end
         OP_IF: begin
            nxt_mask = if_mask;
            nxt_skip = ~|if_mask;
         end
         OP_ELSE: begin
            if (empty) begin
               err_set = 1'b1;
            end else begin
               nxt_mask = else_mask;
               nxt_skip = ~|else_mask;
            end
         end
         OP_RESTORE: begin
            if (empty) begin
               err_set = 1'b1;
            end else begin
               nxt_mask = top;
               pop      = 1'b1;
            end
         end
         OP_TEST: nxt_skip = ~|mask;
         default: ;
      endcase
   end
endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit
   import lane_mask_pkg::*;
#(
   parameter int LANES = 64,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [LANES-1:0] valid_lanes,
   input  logic [2:0]       op,
   input  logic [LANES-1:0] cmp,
   input  logic [LANES-1:0] wb_req,
   output logic [LANES-1:0] exec_mask,
   output logic             skip,
   output logic             stk_err,
   output logic [LANES-1:0] wb_en
);
   logic [LANES-1:0] top;
   logic             empty;
   logic             full;
   logic [LANES-1:0] nxt_mask;
   logic             nxt_skip;
   logic             push;
   logic             pop;
   logic             err_set;
   mask_op_e         op_e;

   assign op_e = mask_op_e'(op);

   lane_mask_next #(.LANES(LANES)) u_next (
      .op       (op_e),
      .cmp      (cmp),
      .mask     (exec_mask),
      .top      (top),
      .empty    (empty),
      .full     (full),
      .nxt_mask (nxt_mask),
      .nxt_skip (nxt_skip),
      .push     (push),
      .pop      (pop),
      .err_set  (err_set)
   );

   lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .push      (push && !launch),
      .pop       (pop && !launch),
      .push_data (exec_mask),
      .top       (top),
      .empty     (empty),
      .full      (full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exec_mask <= '1;
         skip      <= 1'b0;
         stk_err   <= 1'b0;
      end else if (launch) begin
         exec_mask <= valid_lanes;
         skip      <= 1'b0;
      end else begin
         exec_mask <= nxt_mask;
         skip      <= nxt_skip;
         if (err_set)
            stk_err <= 1'b1;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_wb
      assign wb_en[i] = wb_req[i] & exec_mask[i];
   end
endmodule

// File: rtl/lane_mask_chk.sv
module lane_mask_chk #(
   parameter int LANES = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             launch,
   input logic [LANES-1:0] valid_lanes,
   input logic [2:0]       op,
   input logic [LANES-1:0] cmp,
   input logic [LANES-1:0] wb_req,
   input logic [LANES-1:0] exec_mask,
   input logic             skip,
   input logic             stk_err,
   input logic [LANES-1:0] wb_en
);
   a_r1_launch_load: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (exec_mask == $past(valid_lanes)) && !skip);

   a_r2_if_narrows: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && op == 3'd2) |=> exec_mask == ($past(cmp) & $past(exec_mask)));

   a_r4_if_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && op == 3'd2) |=> skip == (exec_mask == '0));

   a_r8_test_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && op == 3'd5) |=> $stable(exec_mask) && (skip == (exec_mask == '0)));

   a_r3_save_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && op == 3'd1) |=> $stable(exec_mask));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stk_err |=> stk_err);

   a_r12_skip_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (launch || (op != 3'd2 && op != 3'd3 && op != 3'd5)) |=> !skip);

   a_r10_wb_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en & ~exec_mask) == '0 && (wb_en & ~wb_req) == '0);
endmodule

bind lane_mask_unit lane_mask_chk #(.LANES(LANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .launch      (launch),
   .valid_lanes (valid_lanes),
   .op          (op),
   .cmp         (cmp),
   .wb_req      (wb_req),
   .exec_mask   (exec_mask),
   .skip        (skip),
   .stk_err     (stk_err),
   .wb_en       (wb_en)
);

// File: tb/lane_mask_unit_bench.sv
module lane_mask_unit_bench;
   localparam int LANES = 64;
   localparam int DEPTH = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             launch = 1'b0;
   logic [LANES-1:0] valid_lanes = '0;
   logic [2:0]       op = 3'd0;
   logic [LANES-1:0] cmp = '0;
   logic [LANES-1:0] wb_req = '0;
   logic [LANES-1:0] exec_mask;
   logic             skip;
   logic             stk_err;
   logic [LANES-1:0] wb_en;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [LANES-1:0] m_mask;
   logic             m_skip;
   logic             m_err;
   logic [LANES-1:0] m_stk[$];

   always #2.5 clk = ~clk;

   lane_mask_unit #(.LANES(LANES), .DEPTH(DEPTH)) u_lane_mask_unit (
      .clk(clk), .rst_n(rst_n), .launch(launch), .valid_lanes(valid_lanes),
      .op(op), .cmp(cmp), .wb_req(wb_req), .exec_mask(exec_mask),
      .skip(skip), .stk_err(stk_err), .wb_en(wb_en)
   );

   task automatic chk(input string tag, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string op_tag(input bit l, input logic [2:0] o);
      if (l) return "R1";
      case (o)
         3'd1: return "R3/R11";
         3'd2: return "R2/R4";
         3'd3: return "R5/R6";
         3'd4: return "R7/R11";
         3'd5: return "R8";
         default: return "R12";
      endcase
   endfunction

   task automatic compare_all(input string tag);
      chk({tag, " mask"}, exec_mask, m_mask);
      chk({tag, " skip"}, LANES'(skip), LANES'(m_skip));
      chk("R9 err", LANES'(stk_err), LANES'(m_err));
      chk("R10 wb_en", wb_en, wb_req & m_mask);
   endtask

   // called at a falling edge; drives, advances the model, checks at the next falling edge
   task automatic cyc(input bit l, input logic [LANES-1:0] v, input logic [2:0] o,
                      input logic [LANES-1:0] c, input string tag);
      logic [LANES-1:0] n;
      launch = l; valid_lanes = v; op = o; cmp = c;
      wb_req = {$urandom, $urandom};
      if (l) begin
         m_mask = v; m_skip = 0; m_stk.delete();
      end else begin
         m_skip = 0;
         case (o)
            3'd1: if (m_stk.size() == DEPTH) m_err = 1; else m_stk.push_back(m_mask);
            3'd2: begin m_mask = c & m_mask; m_skip = (m_mask == '0); end
            3'd3: if (m_stk.size() == 0) m_err = 1;
                  else begin
                     n = m_stk[m_stk.size()-1] & ~m_mask;
                     m_mask = n; m_skip = (n == '0);
                  end
            3'd4: if (m_stk.size() == 0) m_err = 1; else m_mask = m_stk.pop_back();
            3'd5: m_skip = (m_mask == '0);
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      compare_all(tag == "" ? op_tag(l, o) : tag);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [LANES-1:0] ones;
      ones = '1;
      m_mask = '1; m_skip = 0; m_err = 0;
      repeat (3) @(negedge clk);
      compare_all("R1 reset");
      rst_n = 1'b1;

      // basic if/else/restore, partial compare
      cyc(0, '0, 3'd1, '0, "");
      cyc(0, '0, 3'd2, 64'h0000_FFFF_0000_00F0, "");
      cyc(0, '0, 3'd0, '0, "R12");
      cyc(0, '0, 3'd3, '0, "");
      cyc(0, '0, 3'd4, '0, "");
      // all-false compare -> skip
      cyc(0, '0, 3'd1, '0, "");
      cyc(0, '0, 3'd2, '0, "R4 empty if");
      cyc(0, '0, 3'd5, '0, "R8 test empty");
      cyc(0, '0, 3'd3, '0, "R6 else full");
      cyc(0, '0, 3'd4, '0, "");
      // all-true compare -> else empty -> skip
      cyc(0, '0, 3'd1, '0, "");
      cyc(0, '0, 3'd2, ones, "");
      cyc(0, '0, 3'd3, '0, "R6 else empty");
      cyc(0, '0, 3'd4, '0, "");
      // launch with partial wavefront
      cyc(1, 64'h0000_0000_FFFF_FFFF, 3'd2, '0, "R1 launch");
      cyc(0, '0, 3'd2, 64'hFFFF_FFFF_0000_0000, "R2 inactive lanes true");
      cyc(0, '0, 3'd5, '0, "R8");
      // deep nesting: 8 saves with narrowing, then overflow
      cyc(1, ones, 3'd0, '0, "R1");
      for (int i = 0; i < DEPTH; i++) begin
         cyc(0, '0, 3'd1, '0, "R11 push");
         cyc(0, '0, 3'd2, ~(64'h1 << i), "R11 narrow");
      end
      cyc(0, '0, 3'd1, '0, "R9 overflow");
      for (int i = 0; i < DEPTH; i++) cyc(0, '0, 3'd4, '0, "R11 pop");
      // underflow on else and restore
      cyc(0, '0, 3'd3, '0, "R9 else empty");
      cyc(0, '0, 3'd4, '0, "R9 restore empty");
      // launch keeps error
      cyc(1, 64'hAAAA_5555_AAAA_5555, 3'd0, '0, "R9 launch keeps err");

      // pseudo-random program
      for (int k = 0; k < 4000; k++) begin
         int r;
         logic [LANES-1:0] c;
         r = $urandom_range(0, 99);
         c = {$urandom, $urandom};
         if ($urandom_range(0, 9) == 0) c = '0;
         if ($urandom_range(0, 9) == 0) c = ones;
         if (r < 2) cyc(1, {$urandom, $urandom}, 3'($urandom_range(0, 7)), c, "");
         else cyc(0, '0, 3'($urandom_range(0, 7)), c, "");
      end

      // reset clears error
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      m_mask = '1; m_skip = 0; m_err = 0; m_stk.delete();
      compare_all("R1 reset again");
      rst_n = 1'b1;
      cyc(0, '0, 3'd5, '0, "R8 full mask");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule